// File: doc/BRIEF.md
# Link-Training Register Snooper

This block sits beside a main-link redriver. It watches the auxiliary channel passively. The requester's bytes and the replier's bytes reach it already decoded and framed. It follows native AUX write requests, keeps any data bytes aimed at the sink's link-configuration registers, and holds those bytes as pending. When the replier's next reply acknowledges the write, the pending bytes are committed. Control outputs come straight from the committed values: which lanes are enabled, the drive level and pre-emphasis level of each lane, and whether the link runs at the high or the low rate.

A separate power controller looks at the hot-plug input and at a main-link activity strobe. It reports two states. Power-down is forced while the sink is unplugged. Low-power is entered when no activity has been seen for a programmable number of cycles, even with a sink attached.

Top module: `aux_train_snoop`

## Requirements
- R1: While rst_ni is low and after it is released, lane_en_o, drive_lvl_o, preemph_lvl_o, link_hbr_o and low_power_o are 0 and power_down_o is 1.
- R2: A request whose first byte (req_sop_i high) has bits 7:4 = 1000b is a native write. Its bytes arrive in this order: {cmd, addr[19:16]}, addr[15:8], addr[7:0], byte count minus 1, then the data bytes. Data byte k is written to address addr+k. The write commits only when the first byte of the next reply has bits 7:4 = 0000b (ACK).
- R3: A reply with any other code in bits 7:4 (NACK 0001b, DEFER 0010b and the rest) discards the pending bytes, and the outputs stay unchanged.
- R4: I2C-over-AUX requests (bit 7 of the first byte = 0) and native reads (1001b) capture nothing, even when an ACK follows.
- R5: A committed byte at address 00100h of 06h sets link_hbr_o to 0, and 0Ah sets it to 1. Any other value leaves link_hbr_o unchanged.
- R6: At 00101h, bits 3:0 equal to 1, 2 or 4 set lane_en_o to 0001b, 0011b or 1111b. Bits 7:4 are ignored. Any other count leaves lane_en_o unchanged.
- R7: The byte at 00103h+l sets lane l. Bits 1:0 go to drive_lvl_o[2l+1:2l] and bits 4:3 go to preemph_lvl_o[2l+1:2l]. Bits 2 and 5 do not affect the outputs.
- R8: Addresses outside 00100h to 00106h, compared on all 20 bits, are ignored. This includes the bytes of a burst that starts before the window or runs past its end.
- R9: A new request start before the reply discards the pending bytes. An ACK that does not follow a native write changes nothing.
- R10: One cycle after hpd_i is sampled low, power_down_o is 1 and low_power_o is 0. power_down_o returns to 0 one cycle after hpd_i is sampled high.
- R11: With hpd_i high, low_power_o rises at the (idle_limit_i+1)-th consecutive clock edge that samples activity_i low. It falls one cycle after activity_i is sampled high.
- R12: The committed outputs change at the clock edge that samples the reply's first byte, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_byte_i | input | 8 | Decoded requester byte |
| req_valid_i | input | 1 | req_byte_i is valid this cycle |
| req_sop_i | input | 1 | req_byte_i is the first byte of a request |
| rep_byte_i | input | 8 | Decoded replier byte |
| rep_valid_i | input | 1 | rep_byte_i is valid this cycle |
| rep_sop_i | input | 1 | rep_byte_i is the first byte of a reply |
| hpd_i | input | 1 | Hot-plug detect from the sink |
| activity_i | input | 1 | Main-link data activity strobe |
| idle_limit_i | input | TIMER_W | Idle cycles before low-power |
| lane_en_o | output | LANES | Active lane enables |
| drive_lvl_o | output | 2*LANES | Drive level, 2 bits per lane |
| preemph_lvl_o | output | 2*LANES | Pre-emphasis level, 2 bits per lane |
| link_hbr_o | output | 1 | 1 = 2.7 Gbps, 0 = 1.62 Gbps |
| power_down_o | output | 1 | Power-down state |
| low_power_o | output | 1 | Low-power state after idle timeout |

## Verification
A parser that slips by one byte moves a burst's data onto the wrong lane or into the rate field. A lost pending-valid bit, or an armed flag that stays set, makes a NACKed or aborted write appear on the outputs. Each of these errors shows on the lane or level outputs in the cycle right after the reply byte. The bench checks every transaction at exactly that point, and it also checks just before the reply, to catch a commit that happens early. An idle counter that is off by one moves the rise of low_power_o by one edge. The bench samples the two edges on either side of that rise.

// File: rtl/aux_snoop_pkg.sv
package aux_snoop_pkg;
  localparam logic [3:0] CMD_NATIVE_WR = 4'b1000;
  localparam logic [3:0] REPLY_ACK     = 4'b0000;
  localparam logic [7:0] RATE_LOW      = 8'h06;
  localparam logic [7:0] RATE_HIGH     = 8'h0A;
  // register offsets from the configuration base
  localparam int OFS_RATE  = 0;
  localparam int OFS_COUNT = 1;
  localparam int OFS_LANE0 = 3;

  typedef enum logic [2:0] {
    PS_IDLE, PS_ADDR_M, PS_ADDR_L, PS_LEN, PS_DATA
  } pstate_e;
endpackage

// File: rtl/aux_req_parser.sv
module aux_req_parser
  import aux_snoop_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  byte_i,
  input  logic        valid_i,
  input  logic        sop_i,
  output logic        req_start_o,
  output logic        wr_start_o,
  output logic        cap_we_o,
  output logic [19:0] cap_addr_o,
  output logic [7:0]  cap_data_o
);
  pstate_e     st_q;
  logic        is_wr_q;
  logic [19:0] addr_q;
  logic [8:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PS_IDLE;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
    end else if (valid_i) begin
      if (sop_i) begin
        is_wr_q       <= (byte_i[7:4] == CMD_NATIVE_WR);
        addr_q[19:16] <= byte_i[3:0];
        st_q          <= PS_ADDR_M;
      end else begin
        unique case (st_q)
          PS_ADDR_M: begin addr_q[15:8] <= byte_i; st_q <= PS_ADDR_L; end
          PS_ADDR_L: begin addr_q[7:0]  <= byte_i; st_q <= PS_LEN;    end
          PS_LEN: begin
            rem_q <= {1'b0, byte_i} + 9'd1;
            st_q  <= PS_DATA;
          end
          PS_DATA: if (rem_q != '0) begin
            addr_q <= addr_q + 20'd1;
            rem_q  <= rem_q - 9'd1;
          end
          default: ;
        endcase
      end
    end
  end

  assign req_start_o = valid_i && sop_i;
  assign wr_start_o  = valid_i && !sop_i && (st_q == PS_LEN) && is_wr_q;
  assign cap_we_o    = valid_i && !sop_i && (st_q == PS_DATA) && is_wr_q && (rem_q != '0);
  assign cap_addr_o  = addr_q;
  assign cap_data_o  = byte_i;

  // R2: consecutive burst bytes go to consecutive addresses
  p_burst_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_we_o && $past(cap_we_o)) |-> (cap_addr_o == $past(cap_addr_o) + 20'd1));
endmodule

// File: rtl/aux_cfg_commit.sv
module aux_cfg_commit
  import aux_snoop_pkg::*;
#(
  parameter int          LANES = 4,
  parameter logic [19:0] BASE  = 20'h00100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_start_i,
  input  logic               wr_start_i,
  input  logic               cap_we_i,
  input  logic [19:0]        cap_addr_i,
  input  logic [7:0]         cap_data_i,
  input  logic [7:0]         rep_byte_i,
  input  logic               rep_valid_i,
  input  logic               rep_sop_i,
  output logic [LANES-1:0]   lane_en_o,
  output logic [2*LANES-1:0] drive_o,
  output logic [2*LANES-1:0] preemph_o,
  output logic               hbr_o
);
  localparam int NREG = OFS_LANE0 + LANES;
  localparam int IW   = $clog2(NREG);

  logic [19:0]     off;
  logic            hit;
  logic [7:0]      pend_d [NREG];
  logic [NREG-1:0] pend_v;
  logic            armed_q;
  logic            rep_hdr, commit;

  assign off     = cap_addr_i - BASE;
  assign hit     = cap_we_i && (cap_addr_i >= BASE) && (off < 20'(NREG));
  assign rep_hdr = rep_valid_i && rep_sop_i;
  assign commit  = rep_hdr && armed_q && (rep_byte_i[7:4] == REPLY_ACK);

  always_ff @(posedge clk_i) begin
    if (hit) pend_d[off[IW-1:0]] <= cap_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v  <= '0;
      armed_q <= 1'b0;
    end else if (rep_hdr || req_start_i) begin
      pend_v  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (hit)        pend_v[off[IW-1:0]] <= 1'b1;
      if (wr_start_i) armed_q <= 1'b1;
    end
  end

  // lane count decode; unsupported counts are rejected
  logic             cnt_ok;
  logic [LANES-1:0] cnt_mask;
  always_comb begin
    cnt_ok   = 1'b0;
    cnt_mask = '0;
    unique case (pend_d[OFS_COUNT][3:0])
      4'd1: begin cnt_ok = 1'b1;        cnt_mask = LANES'(4'h1); end
      4'd2: begin cnt_ok = (LANES >= 2); cnt_mask = LANES'(4'h3); end
      4'd4: begin cnt_ok = (LANES >= 4); cnt_mask = LANES'(4'hF); end
      default: ;
    endcase
  end

  logic rate_ok;
  assign rate_ok = (pend_d[OFS_RATE] == RATE_LOW) || (pend_d[OFS_RATE] == RATE_HIGH);

  logic [LANES-1:0] lane_en_q;
  logic             hbr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_en_q <= '0;
      hbr_q     <= 1'b0;
    end else if (commit) begin
      if (pend_v[OFS_RATE] && rate_ok)  hbr_q     <= (pend_d[OFS_RATE] == RATE_HIGH);
      if (pend_v[OFS_COUNT] && cnt_ok)  lane_en_q <= cnt_mask;
    end
  end
  assign lane_en_o = lane_en_q;
  assign hbr_o     = hbr_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [1:0] drv_q, pre_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        drv_q <= '0;
        pre_q <= '0;
      end else if (commit && pend_v[OFS_LANE0+l]) begin
        drv_q <= pend_d[OFS_LANE0+l][1:0];
        pre_q <= pend_d[OFS_LANE0+l][4:3];
      end
    end
    assign drive_o[2*l +: 2]   = drv_q;
    assign preemph_o[2*l +: 2] = pre_q;
  end

  // R3: a non-ACK reply leaves every output alone
  p_nack_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_hdr && rep_byte_i[7:4] != REPLY_ACK) |=>
      ($stable(lane_en_o) && $stable(hbr_o) && $stable(drive_o) && $stable(preemph_o)));
  // R12: outputs only move on a reply header edge
  p_commit_on_reply_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rep_hdr |=> ($stable(lane_en_o) && $stable(hbr_o) && $stable(drive_o) && $stable(preemph_o)));
  // R6: enables always form a contiguous run from lane 0
  always_comb begin
    if (rst_ni) p_lane_contig_r6: assert ((lane_en_o & (lane_en_o + LANES'(1))) == '0);
  end
endmodule

// File: rtl/aux_pwr_ctrl.sv
module aux_pwr_ctrl #(
  parameter int TIMER_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hpd_i,
  input  logic               act_i,
  input  logic [TIMER_W-1:0] limit_i,
  output logic               pd_o,
  output logic               lp_o
);
  logic [TIMER_W-1:0] cnt_q;
  logic               lp_q, pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lp_q  <= 1'b0;
      pd_q  <= 1'b1;
    end else begin
      pd_q <= !hpd_i;
      if (!hpd_i || act_i) begin
        cnt_q <= '0;
        lp_q  <= 1'b0;
      end else if (cnt_q >= limit_i) begin
        lp_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + TIMER_W'(1);
      end
    end
  end
  assign pd_o = pd_q;
  assign lp_o = lp_q;

  p_unplug_pd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hpd_i |=> (pd_o && !lp_o));
  p_act_wakes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> !lp_o);
  p_lp_needs_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lp_o) |-> ($past(hpd_i) && !$past(act_i)));
endmodule

// File: rtl/aux_train_snoop.sv
module aux_train_snoop #(
  parameter int          LANES   = 4,
  parameter int          TIMER_W = 24,
  parameter logic [19:0] BASE    = 20'h00100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         req_byte_i,
  input  logic               req_valid_i,
  input  logic               req_sop_i,
  input  logic [7:0]         rep_byte_i,
  input  logic               rep_valid_i,
  input  logic               rep_sop_i,
  input  logic               hpd_i,
  input  logic               activity_i,
  input  logic [TIMER_W-1:0] idle_limit_i,
  output logic [LANES-1:0]   lane_en_o,
  output logic [2*LANES-1:0] drive_lvl_o,
  output logic [2*LANES-1:0] preemph_lvl_o,
  output logic               link_hbr_o,
  output logic               power_down_o,
  output logic               low_power_o
);
  logic        req_start, wr_start, cap_we;
  logic [19:0] cap_addr;
  logic [7:0]  cap_data;

  aux_req_parser u_parser (
    .clk_i, .rst_ni,
    .byte_i(req_byte_i), .valid_i(req_valid_i), .sop_i(req_sop_i),
    .req_start_o(req_start), .wr_start_o(wr_start),
    .cap_we_o(cap_we), .cap_addr_o(cap_addr), .cap_data_o(cap_data)
  );

  aux_cfg_commit #(.LANES(LANES), .BASE(BASE)) u_commit (
    .clk_i, .rst_ni,
    .req_start_i(req_start), .wr_start_i(wr_start),
    .cap_we_i(cap_we), .cap_addr_i(cap_addr), .cap_data_i(cap_data),
    .rep_byte_i, .rep_valid_i, .rep_sop_i,
    .lane_en_o, .drive_o(drive_lvl_o), .preemph_o(preemph_lvl_o), .hbr_o(link_hbr_o)
  );

  aux_pwr_ctrl #(.TIMER_W(TIMER_W)) u_pwr (
    .clk_i, .rst_ni,
    .hpd_i, .act_i(activity_i), .limit_i(idle_limit_i),
    .pd_o(power_down_o), .lp_o(low_power_o)
  );
endmodule

// File: tb/aux_train_snoop_test.sv
`timescale 1ns/1ps
module aux_train_snoop_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  req_byte_i = '0, rep_byte_i = '0;
  logic        req_valid_i = 0, req_sop_i = 0, rep_valid_i = 0, rep_sop_i = 0;
  logic        hpd_i = 0, activity_i = 0;
  logic [23:0] idle_limit_i = 24'd1000;
  logic [3:0]  lane_en_o;
  logic [7:0]  drive_lvl_o, preemph_lvl_o;
  logic        link_hbr_o, power_down_o, low_power_o;

  always #10 clk_i = ~clk_i;

  aux_train_snoop uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  cmd;
    logic [19:0] addr;
    logic [2:0]  n;
    logic [55:0] data;
    logic [3:0]  rep;
    logic [3:0]  lane;
    logic [7:0]  drv;
    logic [7:0]  pre;
    logic        hbr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'h8, 20'h00100, 3'd2, 56'h0A_04_00_00_00_00_00, 4'h0, 4'hF, 8'h00, 8'h00, 1'b1}, // R2 R5 R6
    '{4'h8, 20'h00103, 3'd4, 56'h01_0A_13_1C_00_00_00, 4'h0, 4'hF, 8'h39, 8'hE4, 1'b1}, // R7
    '{4'h8, 20'h00101, 3'd1, 56'h02_00_00_00_00_00_00, 4'h1, 4'hF, 8'h39, 8'hE4, 1'b1}, // R3 NACK
    '{4'h8, 20'h00101, 3'd1, 56'h02_00_00_00_00_00_00, 4'h2, 4'hF, 8'h39, 8'hE4, 1'b1}, // R3 DEFER
    '{4'h8, 20'h00101, 3'd1, 56'h03_00_00_00_00_00_00, 4'h0, 4'hF, 8'h39, 8'hE4, 1'b1}, // R6 bad count
    '{4'h8, 20'h00101, 3'd1, 56'hF2_00_00_00_00_00_00, 4'h0, 4'h3, 8'h39, 8'hE4, 1'b1}, // R6 upper bits
    '{4'h0, 20'h00100, 3'd1, 56'h06_00_00_00_00_00_00, 4'h0, 4'h3, 8'h39, 8'hE4, 1'b1}, // R4 i2c
    '{4'h9, 20'h00100, 3'd1, 56'h06_00_00_00_00_00_00, 4'h0, 4'h3, 8'h39, 8'hE4, 1'b1}, // R4 read
    '{4'h8, 20'h00100, 3'd7, 56'h06_01_00_00_1B_00_00, 4'h0, 4'h1, 8'h0C, 8'h0C, 1'b0}, // R2 burst
    '{4'h8, 20'h00100, 3'd1, 56'h07_00_00_00_00_00_00, 4'h0, 4'h1, 8'h0C, 8'h0C, 1'b0}, // R5 reserved
    '{4'h8, 20'h000FF, 3'd2, 56'h77_0A_00_00_00_00_00, 4'h0, 4'h1, 8'h0C, 8'h0C, 1'b1}, // R8 low edge
    '{4'h8, 20'h00106, 3'd2, 56'h1F_02_00_00_00_00_00, 4'h0, 4'h1, 8'hCC, 8'hCC, 1'b1}, // R8 high edge
    '{4'h8, 20'h10101, 3'd1, 56'h04_00_00_00_00_00_00, 4'h0, 4'h1, 8'hCC, 8'hCC, 1'b1}  // R8 upper addr
  };

  task automatic send_req(logic [3:0] cmd, logic [19:0] addr, logic [2:0] n, logic [55:0] data);
    @(negedge clk_i);
    req_valid_i = 1; req_sop_i = 1; req_byte_i = {cmd, addr[19:16]};
    @(negedge clk_i); req_sop_i = 0; req_byte_i = addr[15:8];
    @(negedge clk_i); req_byte_i = addr[7:0];
    @(negedge clk_i); req_byte_i = {5'd0, n} - 8'd1;
    for (int i = 0; i < int'(n); i++) begin
      @(negedge clk_i); req_byte_i = data[55-8*i -: 8];
    end
    @(negedge clk_i); req_valid_i = 0; req_byte_i = '0;
  endtask

  task automatic send_rep(logic [3:0] code);
    @(negedge clk_i); rep_valid_i = 1; rep_sop_i = 1; rep_byte_i = {code, 4'h0};
    @(negedge clk_i); rep_valid_i = 0; rep_sop_i = 0; rep_byte_i = '0;
  endtask

  function automatic logic [31:0] cfg();
    return {11'd0, lane_en_o, drive_lvl_o, preemph_lvl_o, link_hbr_o};
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 in reset cfg", cfg(), 32'h0);
    chk("R1 in reset pwr", {power_down_o, low_power_o}, 2'b10);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 after reset cfg", cfg(), 32'h0);

    for (int v = 0; v < NV; v++) begin
      send_req(VECS[v].cmd, VECS[v].addr, VECS[v].n, VECS[v].data);
      send_rep(VECS[v].rep);
      checks++;
      if (cfg() !== {11'd0, VECS[v].lane, VECS[v].drv, VECS[v].pre, VECS[v].hbr}) begin
        fails++;
        $display("FAIL R2..R8 vector %0d actual=%h expected=%h", v, cfg(),
                 {11'd0, VECS[v].lane, VECS[v].drv, VECS[v].pre, VECS[v].hbr});
      end
    end

    // R9: aborted write, then orphan ACK
    send_req(4'h8, 20'h00101, 3'd1, 56'h04_00_00_00_00_00_00);
    send_req(4'h9, 20'h00100, 3'd1, 56'h0);
    send_rep(4'h0);
    chk("R9 aborted write", {28'd0, lane_en_o}, 32'h1);
    send_rep(4'h0);
    chk("R9 orphan ACK", {28'd0, lane_en_o}, 32'h1);

    // R12: nothing visible before the reply, visible right after
    send_req(4'h8, 20'h00101, 3'd1, 56'h02_00_00_00_00_00_00);
    chk("R12 before reply", {28'd0, lane_en_o}, 32'h1);
    send_rep(4'h0);
    chk("R12 after reply", {28'd0, lane_en_o}, 32'h3);

    // R10: plug in
    hpd_i = 1; idle_limit_i = 24'd5;
    @(negedge clk_i);
    chk("R10 plug in", {power_down_o, low_power_o}, 2'b00);
    // R11: idle timeout after limit+1 idle edges
    activity_i = 1;
    @(negedge clk_i); activity_i = 0;
    repeat (5) @(negedge clk_i);
    chk("R11 not yet low power", low_power_o, 1'b0);
    @(negedge clk_i);
    chk("R11 low power entered", low_power_o, 1'b1);
    // R10: unplug forces power-down, clears low-power
    hpd_i = 0;
    @(negedge clk_i);
    chk("R10 unplug", {power_down_o, low_power_o}, 2'b10);
    hpd_i = 1;
    repeat (8) @(negedge clk_i);
    chk("R11 idle again", {power_down_o, low_power_o}, 2'b01);
    activity_i = 1;
    @(negedge clk_i); activity_i = 0;
    chk("R11 activity wakes", low_power_o, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule